// File: doc/BRIEF.md
# Dual-Mode FIFO with Selectable Overflow Protection

A single-clock first-in first-out buffer of 4096 words of 12 bits with a registered data output. Writes and reads are requested by active-low enables. Each pointer has its own active-low clear input. Two threshold registers are programmed from the data input through a load strobe and a one-bit register select. From the occupancy the block derives four flags: full, empty, almost-full and almost-empty.

The level of each enable in the cycle where its pointer is cleared selects the operating mode. In guarded mode the full and empty flags block writes beyond full and reads beyond empty. If both clears are taken with their enables low, the block enters wrap mode. There every requested access is carried out, the pointers wrap modulo the depth, and a write into a full array overwrites the oldest unread word. Wrap mode suits circular delay or recirculation uses, where the flags have no meaning.

Top module: `dual_mode_fifo`

## Requirements
- R1: After rst_ni is released: empty_n_o=0, full_n_o=1, afull_n_o=1, aempty_n_o=0, dout_o=0, both thresholds 0, guarded mode, both pointers at location 0.
- R2: A read (rd_ni=0, accepted) places the oldest unread word on dout_o at the clock edge that performs it. Words leave in the order they were written.
- R3: full_n_o is 0 exactly when 4096 unread words are held. In guarded mode a write request while full_n_o=0 is dropped and changes no state.
- R4: In guarded mode a read request while empty_n_o=0 is dropped, and dout_o keeps the last word read.
- R5: While rd_ni=1, dout_o does not change.
- R6: empty_n_o is 0 exactly when the write and read pointers are equal, which means zero unread words.
- R7: afull_n_o is 0 when the unread count is at least 4096 - N, where N is the almost-full threshold.
- R8: aempty_n_o is 1 when the unread count is at least N + 1, where N is the almost-empty threshold. Otherwise it is 0.
- R9: When ld_ni=0 and wr_ni=0 on an edge, din_i loads the almost-empty threshold (thr_sel_i=0) or the almost-full threshold (thr_sel_i=1). No word is written to the array in that cycle.
- R10: A cycle with wptr_rst_ni=0 records wr_ni, and a cycle with rptr_rst_ni=0 records rd_ni. Wrap mode holds only when both recorded levels were 0. Otherwise the block is in guarded mode.
- R11: In wrap mode every requested access is performed. A write with 4096 words unread goes to the oldest location and overwrites it. A read with the pointers equal returns the stale word at the read location.
- R12: A pointer clear sets that pointer to location 0, and no access happens on that side in that cycle. Clearing both pointers makes the FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for writes, reads and flags |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ni | input | 1 | Write request, active low |
| rd_ni | input | 1 | Read request, active low |
| wptr_rst_ni | input | 1 | Write pointer clear, active low |
| rptr_rst_ni | input | 1 | Read pointer clear, active low |
| ld_ni | input | 1 | Threshold load strobe, active low (acts with wr_ni=0) |
| thr_sel_i | input | 1 | Threshold select: 0 almost-empty, 1 almost-full |
| din_i | input | 12 | Write data or threshold value |
| dout_o | output | 12 | Registered read data |
| full_n_o | output | 1 | Full flag, active low |
| empty_n_o | output | 1 | Empty flag, active low |
| afull_n_o | output | 1 | Almost-full flag, active low |
| aempty_n_o | output | 1 | Almost-empty flag: 0 while count <= threshold |

## Verification
The hardest state to reach is wrap mode with the array already holding 4096 unread words. Only in that state can a write overwrite unread data, and a read with equal pointers return a stale word. The stimulus clears both pointers with both enables low and writes 4099 words, so the last three land on the oldest locations. It then reads those locations and drains until the pointers meet, followed by one more read that must return the stale word at the fourth location. A mixed clear, with only the write side taking the wrap level, must leave the empty guard in force.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned ADDR_W = 12;
  typedef enum logic {MODE_GUARDED = 1'b0, MODE_WRAP = 1'b1} fifo_mode_e;
endpackage

// File: rtl/lbf_ptr.sv
module lbf_ptr #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_ni,
  input  logic          en_ni,
  input  logic          go_i,
  output logic [AW:0]   ptr_o,
  output logic          wrap_sel_o,
  output logic          step_o
);
  assign step_o = clr_ni & ~en_ni & go_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o      <= '0;
      wrap_sel_o <= 1'b0;
    end else if (!clr_ni) begin
      ptr_o      <= '0;
      wrap_sel_o <= ~en_ni;  // enable level at clear picks the mode
    end else if (step_o) begin
      ptr_o      <= ptr_o + (AW+1)'(1);
    end
  end
endmodule

// File: rtl/lbf_ram.sv
module lbf_ram #(
  parameter int DW = 12,
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] dout_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // read sees the word held before a same-edge write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_o <= '0;
    else if (re_i) dout_o <= mem[raddr_i];
  end

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(dout_o));
endmodule

// File: rtl/lbf_flags.sv
module lbf_flags #(
  parameter int DW = 12,
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic          sel_i,
  input  logic [DW-1:0] din_i,
  input  logic [AW:0]   wptr_i,
  input  logic [AW:0]   rptr_i,
  output logic          full_n_o,
  output logic          empty_n_o,
  output logic          afull_n_o,
  output logic          aempty_n_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] ae_q, af_q;
  logic [AW:0]   cnt;
  logic [31:0]   cnt32, af_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q <= '0;
      af_q <= '0;
    end else if (ld_i) begin
      if (sel_i) af_q <= din_i;
      else       ae_q <= din_i;
    end
  end

  assign cnt        = wptr_i - rptr_i;  // extra bit tells 0 from DEPTH
  assign cnt32      = 32'(cnt);
  assign af_lim     = DEPTH - 32'(af_q);
  assign empty_n_o  = (cnt32 != 32'd0);
  assign full_n_o   = (cnt32 != DEPTH);
  assign afull_n_o  = (cnt32 < af_lim);
  assign aempty_n_o = (cnt32 > 32'(ae_q));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import lbf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_ni,
  input  logic          rd_ni,
  input  logic          wptr_rst_ni,
  input  logic          rptr_rst_ni,
  input  logic          ld_ni,
  input  logic          thr_sel_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          full_n_o,
  output logic          empty_n_o,
  output logic          afull_n_o,
  output logic          aempty_n_o
);
  fifo_mode_e  mode;
  logic        w_wrap, r_wrap, w_go, r_go, w_step, r_step, thr_ld;
  logic [AW:0] wptr, rptr;

  assign mode   = (w_wrap & r_wrap) ? MODE_WRAP : MODE_GUARDED;
  assign w_go   = ld_ni & ((mode == MODE_WRAP) | full_n_o);
  assign r_go   = (mode == MODE_WRAP) | empty_n_o;
  assign thr_ld = ~ld_ni & ~wr_ni;

  lbf_ptr #(.AW(AW)) u_wptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(wptr_rst_ni), .en_ni(wr_ni),
    .go_i(w_go), .ptr_o(wptr), .wrap_sel_o(w_wrap), .step_o(w_step));

  lbf_ptr #(.AW(AW)) u_rptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(rptr_rst_ni), .en_ni(rd_ni),
    .go_i(r_go), .ptr_o(rptr), .wrap_sel_o(r_wrap), .step_o(r_step));

  lbf_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(w_step), .waddr_i(wptr[AW-1:0]),
    .wdata_i(din_i), .re_i(r_step), .raddr_i(rptr[AW-1:0]), .dout_o(dout_o));

  lbf_flags #(.DW(DW), .AW(AW)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(thr_ld), .sel_i(thr_sel_i),
    .din_i(din_i), .wptr_i(wptr), .rptr_i(rptr), .full_n_o(full_n_o),
    .empty_n_o(empty_n_o), .afull_n_o(afull_n_o), .aempty_n_o(aempty_n_o));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_GUARDED && !full_n_o && !wr_ni && ld_ni && wptr_rst_ni)
      |=> $stable(wptr));

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_GUARDED && !empty_n_o && !rd_ni && rptr_rst_ni)
      |=> ($stable(rptr) && $stable(dout_o)));

  assert_load_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_ni && !wr_ni && wptr_rst_ni) |=> $stable(wptr));

  assert_wrap_select_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wptr_rst_ni && !rptr_rst_ni && !wr_ni && !rd_ni) |=> (mode == MODE_WRAP));

  assert_clear_empty_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wptr_rst_ni && !rptr_rst_ni) |=> !empty_n_o);
endmodule

// File: tb/sim_dual_mode_fifo.sv
`timescale 1ns/1ps
module sim_dual_mode_fifo;
  localparam int DEPTH = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1, wrst_n = 1'b1, rrst_n = 1'b1, ld_n = 1'b1, sel = 1'b0;
  logic [11:0] din = '0;
  logic [11:0] dout;
  logic full_n, empty_n, afull_n, aempty_n;

  int n_chk = 0, n_err = 0;
  bit done = 0, cmp_on = 0;

  // reference model state
  int m_wp, m_rp, m_ww, m_rw, m_ae, m_af, m_dout, m_cnt;
  bit m_wrap, do_r, do_w;
  int m_mem [DEPTH];

  always #10 clk = ~clk;

  dual_mode_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_ni(wr_n), .rd_ni(rd_n),
    .wptr_rst_ni(wrst_n), .rptr_rst_ni(rrst_n), .ld_ni(ld_n), .thr_sel_i(sel),
    .din_i(din), .dout_o(dout), .full_n_o(full_n), .empty_n_o(empty_n),
    .afull_n_o(afull_n), .aempty_n_o(aempty_n));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wp = 0; m_rp = 0; m_ww = 0; m_rw = 0; m_ae = 0; m_af = 0; m_dout = 0;
    end else begin
      m_wrap = (m_ww != 0) && (m_rw != 0);
      m_cnt  = m_wp - m_rp;
      do_r = rrst_n && !rd_n && (m_wrap || m_cnt != 0);
      do_w = wrst_n && !wr_n && ld_n && (m_wrap || m_cnt < DEPTH);
      if (do_r) begin m_dout = m_mem[m_rp % DEPTH]; m_rp++; end
      if (do_w) begin m_mem[m_wp % DEPTH] = int'(din); m_wp++; end
      if (!ld_n && !wr_n) begin
        if (sel) m_af = int'(din); else m_ae = int'(din);
      end
      if (!wrst_n) begin m_wp = 0; m_ww = int'(!wr_n); end
      if (!rrst_n) begin m_rp = 0; m_rw = int'(!rd_n); end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int c;
      c = m_wp - m_rp;
      chk("R2 dout", int'(dout), m_dout);
      if (!(m_ww != 0 && m_rw != 0)) begin
        chk("R6 empty_n", int'(empty_n), int'(c != 0));
        chk("R3 full_n", int'(full_n), int'(c != DEPTH));
        chk("R7 afull_n", int'(afull_n), int'(c < DEPTH - m_af));
        chk("R8 aempty_n", int'(aempty_n), int'(c > m_ae));
      end
    end
  end

  function automatic logic [11:0] pat(input int i);
    return 12'((i * 37 + 5) & 32'hFFF);
  endfunction

  task automatic cyc(input logic w, input logic r, input logic [11:0] d);
    wr_n = w; rd_n = r; din = d;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic prst(input logic w, input logic r);
    wrst_n = 1'b0; rrst_n = 1'b0; wr_n = w; rd_n = r;
    @(negedge clk);
    wrst_n = 1'b1; rrst_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input logic s, input logic [11:0] v);
    ld_n = 1'b0; wr_n = 1'b0; sel = s; din = v;
    @(negedge clk);
    ld_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R2 act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 empty_n", int'(empty_n), 0);
    chk("R1 full_n", int'(full_n), 1);
    chk("R1 afull_n", int'(afull_n), 1);
    chk("R1 aempty_n", int'(aempty_n), 0);
    chk("R1 dout", int'(dout), 0);
    cmp_on = 1;

    // guarded mode, clear after a few words
    prst(1'b1, 1'b1);
    cyc(1'b0, 1'b1, 12'h111);
    cyc(1'b0, 1'b1, 12'h222);
    prst(1'b1, 1'b1);
    chk("R12 empty after clear", int'(empty_n), 0);

    load(1'b0, 12'd3);
    load(1'b1, 12'd10);
    chk("R9 load wrote no word", int'(empty_n), 0);

    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, pat(i));
    chk("R8 count 3 thr 3", int'(aempty_n), 0);
    cyc(1'b0, 1'b1, pat(3));
    chk("R8 count 4 thr 3", int'(aempty_n), 1);
    for (int i = 4; i < 4085; i++) cyc(1'b0, 1'b1, pat(i));
    chk("R7 count 4085 thr 10", int'(afull_n), 1);
    cyc(1'b0, 1'b1, pat(4085));
    chk("R7 count 4086 thr 10", int'(afull_n), 0);
    for (int i = 4086; i < 4096; i++) cyc(1'b0, 1'b1, pat(i));
    chk("R3 full at 4096", int'(full_n), 0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 12'hABC);
    chk("R3 still full", int'(full_n), 0);

    cyc(1'b1, 1'b0, 12'h0);
    chk("R2 first word", int'(dout), int'(pat(0)));
    cyc(1'b1, 1'b1, 12'h0);
    cyc(1'b1, 1'b1, 12'h0);
    chk("R5 hold", int'(dout), int'(pat(0)));
    for (int i = 1; i < 4096; i++) cyc(1'b1, 1'b0, 12'h0);
    chk("R2 last word", int'(dout), int'(pat(4095)));
    chk("R6 empty after drain", int'(empty_n), 0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 12'h0);
    chk("R4 dout held when empty", int'(dout), int'(pat(4095)));

    for (int i = 0; i < 400; i++)
      cyc(1'($urandom % 2), 1'($urandom % 2), 12'($urandom));

    // wrap mode
    prst(1'b0, 1'b0);
    for (int i = 0; i < 4099; i++) cyc(1'b0, 1'b1, pat(i + 100));
    cyc(1'b1, 1'b0, 12'h0);
    chk("R11 overwrite of oldest", int'(dout), int'(pat(4196)));
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 12'h0);
    chk("R11 untouched location", int'(dout), int'(pat(103)));
    for (int i = 0; i < 4095; i++) cyc(1'b1, 1'b0, 12'h0);
    cyc(1'b1, 1'b0, 12'h0);
    chk("R11 stale read when equal", int'(dout), int'(pat(103)));

    // only one side takes the wrap level: guarded
    prst(1'b0, 1'b1);
    cyc(1'b0, 1'b1, pat(7));
    cyc(1'b1, 1'b0, 12'h0);
    chk("R10 read of written word", int'(dout), int'(pat(7)));
    cyc(1'b1, 1'b0, 12'h0);
    chk("R10 guarded read blocked", int'(dout), int'(pat(7)));

    prst(1'b1, 1'b1);
    chk("R12 final clear", int'(empty_n), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule